// File: doc/BRIEF.md
# Predicate Pattern Initializer

This block produces the full contents of a vector predicate register in one request. A predicate carries one bit per byte of the vector. The element size groups those bits into elements, and only the lowest bit of each element is significant. A caller supplies three things: the current vector length in bytes, an element size, and a 5-bit pattern code. From these the block works out how many leading elements are active. It sets the significant bit of each of those elements and clears every other bit, including all bits past the vector length.

The pattern code can select any of these counts:
- the largest power of two that fits;
- a fixed count, which falls to zero rather than being clamped when it does not fit;
- the element count rounded down to a multiple of three or of four;
- every element.

Two controls cover the special cases. The clear control forces an all-false result. The fill control sets every byte of the vector, as done when a fault-tracking register is set. When the caller asks for flags, the block also returns condition flags that tell whether any element became active.

A request is taken on any rising clock edge where `req_valid` is high. The element count is computed combinationally. The predicate and flags are registered at that same edge, and `done` is high for the one cycle that follows.

Top module: `pred_pattern_init`

## Requirements
- R1: The element count is `vl_bytes >> elem_size`, where elem_size encodes 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. Pattern 0x1F makes all of these elements active.
- R2: Pattern 0x00 activates the largest power of two that is not above the element count. It activates zero when the element count is zero.
- R3: Patterns 0x01 to 0x08 activate exactly that many elements when that many exist, and zero elements otherwise.
- R4: Patterns 0x09 to 0x0D request 16 << (pattern − 9) elements (16, 32, 64, 128 or 256). Such a request is granted in full when it fits and gives zero otherwise.
- R5: Pattern 0x1D gives the element count rounded down to a multiple of 4, and pattern 0x1E gives it rounded down to a multiple of 3.
- R6: Pattern codes 0x0E to 0x1C give zero active elements.
- R7: For active count n, `pred_o` bit (k << elem_size) is 1 for every k < n, and every other bit of `pred_o` is 0. This includes all bits at or above `vl_bytes`.
- R8: When `force_false` is high, `pred_o` becomes all zero whatever the pattern, element size and `force_fill` are.
- R9: When `force_fill` is high and `force_false` is low, bits 0 to `vl_bytes`−1 of `pred_o` are set and the rest are cleared, ignoring `elem_size` and `pattern`.
- R10: With `set_flags` high on a request, the flags are loaded as follows. If any element is active: flag_n = 1, flag_z = 0, flag_c = 0. If none is active: flag_n = 0, flag_z = 1, flag_c = 1. In both cases flag_v = 0.
- R11: A request with `set_flags` low, or a cycle with no request, leaves all four flags unchanged.
- R12: Outputs update on the edge that samples `req_valid` high. `done` is 1 for exactly the following cycle, and `pred_o` holds its value between requests.
- R13: While reset is asserted, `pred_o` is all zero, `done` is 0 and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled on the rising edge |
| vl_bytes | input | VL_W | Vector length in bytes, at most MAX_VL_BYTES |
| elem_size | input | 2 | Element size: 0 byte, 1 half, 2 word, 3 double |
| pattern | input | 5 | Count pattern code |
| force_false | input | 1 | Force an all-false predicate |
| force_fill | input | 1 | Set every byte bit up to the vector length |
| set_flags | input | 1 | Load the condition flags with this request |
| done | output | 1 | One-cycle strobe after each request |
| pred_o | output | MAX_VL_BYTES | Registered predicate, one bit per byte |
| flag_n | output | 1 | Negative flag (any element active) |
| flag_z | output | 1 | Zero flag (no element active) |
| flag_c | output | 1 | Carry flag (no element active) |
| flag_v | output | 1 | Overflow flag, always loaded with 0 |

## Verification
Every cycle, the assertions check the structural shape of the result:
- no predicate bit at or above the sampled vector length;
- no bit off the element grid;
- an all-zero result under the clear control;
- the negative flag agreeing with whether the predicate is non-zero;
- the predicate and flags holding when not loaded.

They cannot show that the count itself is right for each pattern. Only the bench's sweep can show that, by covering every vector length, element size and pattern code of a 64-byte configuration against arithmetic expectations. The fill and clear overrides, flag retention across requests without flags, and the reset values are likewise shown by bench scenarios.

// File: rtl/pred_init_pkg.sv
package pred_init_pkg;

  typedef enum logic [1:0] {
    ESZ_BYTE = 2'd0,
    ESZ_HALF = 2'd1,
    ESZ_WORD = 2'd2,
    ESZ_DBL  = 2'd3
  } esz_e;

  localparam logic [4:0] PAT_POW2      = 5'h00;
  localparam logic [4:0] PAT_FIX_LO    = 5'h01;
  localparam logic [4:0] PAT_FIX_HI    = 5'h08;
  localparam logic [4:0] PAT_BIG_LO    = 5'h09;
  localparam logic [4:0] PAT_BIG_HI    = 5'h0D;
  localparam logic [4:0] PAT_MUL4      = 5'h1D;
  localparam logic [4:0] PAT_MUL3      = 5'h1E;
  localparam logic [4:0] PAT_EVERY     = 5'h1F;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/pred_count_decode.sv
module pred_count_decode
  import pred_init_pkg::*;
#(
  parameter int VL_W = 9
) (
  input  logic [VL_W-1:0] vl_bytes,
  input  logic [1:0]      esz,
  input  logic [4:0]      pattern,
  input  logic            zero_req,
  output logic [VL_W-1:0] count
);

  localparam int BW = ((VL_W > 9) ? VL_W : 9) + 1;

  logic [VL_W-1:0] elements;
  logic [VL_W-1:0] pow2_cnt;
  logic [VL_W-1:0] mul4_cnt;
  logic [VL_W-1:0] mul3_cnt;
  logic [BW-1:0]   bound;
  logic [BW-1:0]   elems_wide;
  logic            is_fixed;
  logic            fits;

  assign elements   = vl_bytes >> esz;
  assign elems_wide = BW'(elements);

  always_comb begin
    pow2_cnt = '0;
    for (int b = 0; b < VL_W; b++) begin
      if (elements[b]) pow2_cnt = VL_W'(1) << b;
    end
  end

  assign mul4_cnt = {elements[VL_W-1:2], 2'b00};
  assign mul3_cnt = elements - (elements % VL_W'(3));

  always_comb begin
    bound    = '0;
    is_fixed = 1'b0;
    if (pattern >= PAT_FIX_LO && pattern <= PAT_FIX_HI) begin
      bound    = BW'(pattern);
      is_fixed = 1'b1;
    end else if (pattern >= PAT_BIG_LO && pattern <= PAT_BIG_HI) begin
      bound    = BW'(16) << (pattern - PAT_BIG_LO);
      is_fixed = 1'b1;
    end
  end

  assign fits = elems_wide >= bound;

  always_comb begin
    count = '0;
    if (!zero_req) begin
      if (is_fixed) begin
        count = fits ? VL_W'(bound) : '0;
      end else begin
        unique case (pattern)
          PAT_POW2:  count = pow2_cnt;
          PAT_MUL4:  count = mul4_cnt;
          PAT_MUL3:  count = mul3_cnt;
          PAT_EVERY: count = elements;
          default:   count = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/pred_mask_build.sv
module pred_mask_build #(
  parameter int PW   = 256,
  parameter int CNT_W = 9
) (
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       esz,
  output logic [PW-1:0]    mask
);

  localparam int SP_W = CNT_W + 3;

  logic [SP_W-1:0] span;
  logic [2:0]      low_bits;

  assign span     = SP_W'(count) << esz;
  assign low_bits = 3'((4'd1 << esz) - 4'd1);

  for (genvar i = 0; i < PW; i++) begin : g_bit
    assign mask[i] = (SP_W'(i) < span) && ((3'(i) & low_bits) == 3'd0);
  end

endmodule

// File: rtl/pred_pattern_init.sv
module pred_pattern_init
  import pred_init_pkg::*;
#(
  parameter int MAX_VL_BYTES = 256,
  localparam int VL_W = $clog2(MAX_VL_BYTES + 1),
  localparam int PW   = MAX_VL_BYTES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VL_W-1:0] vl_bytes,
  input  logic [1:0]      elem_size,
  input  logic [4:0]      pattern,
  input  logic            force_false,
  input  logic            force_fill,
  input  logic            set_flags,
  output logic            done,
  output logic [PW-1:0]   pred_o,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_c,
  output logic            flag_v
);

  logic [1:0]      eff_esz;
  logic [4:0]      eff_pat;
  logic [VL_W-1:0] act_cnt;
  logic [PW-1:0]   mask_d;
  logic            any_act;

  logic [PW-1:0]   pred_q, pred_d;
  logic            done_q, done_d;
  flags_t          flags_q, flags_d;
  logic            pred_en, flags_en;

  assign eff_esz = force_fill ? ESZ_BYTE  : elem_size;
  assign eff_pat = force_fill ? PAT_EVERY : pattern;

  pred_count_decode #(.VL_W(VL_W)) u_count (
    .vl_bytes (vl_bytes),
    .esz      (eff_esz),
    .pattern  (eff_pat),
    .zero_req (force_false),
    .count    (act_cnt)
  );

  pred_mask_build #(.PW(PW), .CNT_W(VL_W)) u_mask (
    .count (act_cnt),
    .esz   (eff_esz),
    .mask  (mask_d)
  );

  assign any_act  = (act_cnt != '0);
  assign pred_en  = req_valid;
  assign flags_en = req_valid && set_flags;

  always_comb begin
    pred_d  = mask_d;
    done_d  = req_valid;
    flags_d = '{n: any_act, z: !any_act, c: !any_act, v: 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_q  <= '0;
      done_q  <= 1'b0;
      flags_q <= '0;
    end else begin
      done_q <= done_d;
      if (pred_en)  pred_q  <= pred_d;
      if (flags_en) flags_q <= flags_d;
    end
  end

  assign done   = done_q;
  assign pred_o = pred_q;
  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

  function automatic logic [PW-1:0] above_vl(input logic [VL_W-1:0] vl);
    logic [PW-1:0] m;
    for (int i = 0; i < PW; i++) m[i] = (i >= int'(vl));
    return m;
  endfunction

  function automatic logic [PW-1:0] off_grid(input logic [1:0] e);
    logic [PW-1:0] m;
    for (int i = 0; i < PW; i++) m[i] = ((i % (1 << e)) != 0);
    return m;
  endfunction

  AST_BEYOND_VL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((pred_o & above_vl($past(vl_bytes))) == '0)); // R7

  AST_ON_ELEM_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((pred_o & off_grid($past(eff_esz))) == '0)); // R7

  AST_FALSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(force_false)) |-> (pred_o == '0)); // R8

  AST_FLAG_N_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(set_flags)) |-> (flag_n == (pred_o != '0)) && !flag_v); // R10

  AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && set_flags) |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R11

  AST_PRED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(pred_o) && !done)); // R12

endmodule

// File: tb/pred_pattern_init_tb.sv
module pred_pattern_init_tb;

  localparam int MAXB = 64;
  localparam int VW   = $clog2(MAXB + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0;
  logic [VW-1:0]   vl_bytes = '0;
  logic [1:0]      elem_size = '0;
  logic [4:0]      pattern = '0;
  logic            force_false = 1'b0;
  logic            force_fill = 1'b0;
  logic            set_flags = 1'b0;
  logic            done;
  logic [MAXB-1:0] pred_o;
  logic            flag_n, flag_z, flag_c, flag_v;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  logic [3:0] exp_flags = 4'b0000;

  always #2.5 clk = ~clk;

  pred_pattern_init #(.MAX_VL_BYTES(MAXB)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .vl_bytes(vl_bytes),
    .elem_size(elem_size), .pattern(pattern), .force_false(force_false),
    .force_fill(force_fill), .set_flags(set_flags), .done(done),
    .pred_o(pred_o), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v)
  );

  function automatic int ref_count(int vl, int e, int p);
    int n = vl >> e;
    int want;
    if (p == 0) begin
      int q = 1;
      if (n == 0) return 0;
      while (q * 2 <= n) q = q * 2;
      return q;
    end
    if (p >= 1 && p <= 8) return (n >= p) ? p : 0;
    if (p >= 9 && p <= 13) begin
      want = 16 << (p - 9);
      return (n >= want) ? want : 0;
    end
    if (p == 29) return (n / 4) * 4;
    if (p == 30) return (n / 3) * 3;
    if (p == 31) return n;
    return 0;
  endfunction

  function automatic logic [MAXB-1:0] ref_mask(int cnt, int e);
    logic [MAXB-1:0] m = '0;
    for (int k = 0; k < cnt; k++) m[k * (1 << e)] = 1'b1;
    return m;
  endfunction

  function automatic string tag_of(int p);
    if (p == 0) return "R2";
    if (p <= 8) return "R3";
    if (p <= 13) return "R4";
    if (p == 29 || p == 30) return "R5";
    if (p == 31) return "R1";
    return "R6";
  endfunction

  task automatic check_bit(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic check_vec(string tag, logic [MAXB-1:0] act, logic [MAXB-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // One request, then one idle cycle (R12 timing and hold checks).
  task automatic do_req(int vl, int e, int p, bit ff, bit fa, bit sf,
                        logic [MAXB-1:0] exp, string tag);
    logic any;
    any = (exp != '0);
    @(negedge clk);
    req_valid = 1'b1; vl_bytes = VW'(vl); elem_size = 2'(e); pattern = 5'(p);
    force_false = ff; force_fill = fa; set_flags = sf;
    @(negedge clk);
    req_valid = 1'b0;
    if (sf) exp_flags = {any, !any, !any, 1'b0};
    check_vec(tag, pred_o, exp);
    check_bit("R12 done", done, 1'b1);
    check_vec(sf ? "R10 flags" : "R11 flags", {flag_n, flag_z, flag_c, flag_v, {(MAXB-4){1'b0}}},
              {exp_flags, {(MAXB-4){1'b0}}});
    @(negedge clk);
    check_bit("R12 done drop", done, 1'b0);
    check_vec("R12 hold", pred_o, exp);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=<150000", cycles);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset values
    check_vec("R13 pred", pred_o, '0);
    check_bit("R13 done", done, 1'b0);
    check_bit("R13 flags", flag_n | flag_z | flag_c | flag_v, 1'b0);
    rst_n = 1'b1;

    // R1..R7: full sweep of length, element size and pattern
    for (int vl = 0; vl <= MAXB; vl++) begin
      for (int e = 0; e < 4; e++) begin
        for (int p = 0; p < 32; p++) begin
          do_req(vl, e, p, 1'b0, 1'b0, ((vl + p + e) % 3) == 0,
                 ref_mask(ref_count(vl, e, p), e), tag_of(p));
        end
      end
    end

    // R7: grid layout for a known case, vl=64 halfwords all -> 0x5555...
    do_req(MAXB, 1, 31, 1'b0, 1'b0, 1'b1, {(MAXB/2){2'b01}}, "R7");

    // R9: fill sets every byte up to the length, any size or pattern
    for (int vl = 0; vl <= MAXB; vl++) begin
      do_req(vl, vl % 4, (vl * 7) % 32, 1'b0, 1'b1, 1'b1, ref_mask(vl, 0), "R9");
    end

    // R8: clear overrides everything, including fill
    for (int vl = 0; vl <= MAXB; vl += 4) begin
      do_req(vl, 0, 31, 1'b1, vl[2], 1'b1, '0, "R8");
    end

    // R11: flags set by an active request, then untouched by requests without flags
    do_req(MAXB, 0, 31, 1'b0, 1'b0, 1'b1, ref_mask(MAXB, 0), "R10");
    do_req(MAXB, 0, 20, 1'b0, 1'b0, 1'b0, '0, "R11");
    do_req(0, 0, 31, 1'b0, 1'b0, 1'b1, '0, "R10");
    do_req(MAXB, 3, 31, 1'b0, 1'b0, 1'b0, ref_mask(8, 3), "R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule